// File: doc/BRIEF.md
# PHY-Side Link Interface Sequencer

This block sits in the physical-layer device and owns the 2-bit control lines and the 4-bit data lines that run to the link-layer controller. When arbitration is won, it grants the interface to the link. It then stops driving the lines and watches the codes the link sends. It forwards the link's packet symbols to the cable transmit path. When the link lets go, it takes the lines back after one turnaround clock. If the link asks to keep the bus after a packet, the block waits a minimum gap and grants again without new arbitration.

When the cable reports data-on, the sequencer starts a receive. It shows a receive prefix, then a speed header, then the packet symbols, and it ends with idle. An acknowledge request that is still pending when the incoming packet ends is granted right away, with no arbitration. The block tells the request decoder that a request was lost whenever a receive starts, and that it was won whenever a grant goes out. Detecting the cable line state, arbitrating and serializing onto the cable are done elsewhere and arrive here as plain inputs.

Control codes depend on which side drives the lines. With this block driving: 00 idle, 10 receive, 11 grant. With the link driving: 00 release, 01 hold, 10 transmit, 11 reserved. The data bus is numbered d[0:3], and a literal such as 4'b0100 sets d[1].

Top module: `phy_link_seq`

## Requirements
- R1: After reset the block drives ctl 00 and d 0000 with both enables high, and won_o, lost_o and tx_vld_o are low.
- R2: When arb_won_i is seen in idle, the block drives ctl 11 for one clock with won_o high, then ctl 00 for one clock, and then drops both enables.
- R3: While the link owns the lines, a sampled link code 10 makes tx_vld_o high in the next clock with that clock's link data on tx_sym_o. At 100 Mbps only d[0:1] are forwarded and tx_sym_o[2:3] read 0. A hold code 01 seen before any packet keeps the enables low and produces no output.
- R4: When the link code is sampled as 00 (release), the enables stay low for one more clock. After that the block drives ctl 00 and d 0000.
- R5: When the code after a packet is 01 and the next code is 00, the block lets one turnaround clock pass. It then drives idle for exactly GAP_CLKS clocks and grants again (ctl 11 with won_o, then 00, then release).
- R6: The transmit speed (req_speed_i: 0 = 100 Mbps, 1 = 200 Mbps) is captured at the first grant of an ownership. It is kept across chained grants, even if req_speed_i changes.
- R7: When rx_dataon_i is seen in idle, the next clock shows ctl 10 with d 1111. lost_o is high for that first receive clock only.
- R8: After rx_pkt_start_i, d carries the speed header (4'b0100 for 200 Mbps, 4'b0000 for 100 Mbps). Each valid symbol then appears on d one clock after rx_sym_vld_i. At 100 Mbps, d[2:3] are 0.
- R9: When rx_dataon_i drops, with or without a packet delivered, the next clock shows ctl 00 and d 0000 with the enables still high.
- R10: If imm_pend_i is high when rx_dataon_i drops, the next clock is a grant (ctl 11, won_o high). No idle clock comes first.
- R11: If rx_dataon_i and arb_won_i arrive in the same idle clock, the receive wins. won_o stays low and no grant follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_won_i | input | 1 | Arbitration for a queued request was won |
| req_speed_i | input | 1 | Speed of the request being granted: 0 = 100, 1 = 200 Mbps |
| imm_pend_i | input | 1 | Acknowledge (immediate) request pending |
| rx_dataon_i | input | 1 | Cable shows data-on |
| rx_pkt_start_i | input | 1 | Packet start detected on the cable |
| rx_speed_i | input | 1 | Speed of the incoming packet: 0 = 100, 1 = 200 Mbps |
| rx_sym_vld_i | input | 1 | Received symbol valid |
| rx_sym_i | input | 4 | Received symbol, d[0:3] order |
| link_ctl_i | input | 2 | Control code sampled from the link |
| link_d_i | input | 4 | Data sampled from the link |
| ctl_o | output | 2 | Control code driven to the link |
| ctl_oe_o | output | 1 | Drive enable for ctl_o |
| d_o | output | 4 | Data driven to the link |
| d_oe_o | output | 1 | Drive enable for d_o |
| won_o | output | 1 | Grant issued (request won) |
| lost_o | output | 1 | Receive started (request lost) |
| tx_vld_o | output | 1 | Link symbol valid towards the cable |
| tx_sym_o | output | 4 | Link symbol towards the cable, speed-masked |

## Verification
The bench builds the sequencer with GAP_CLKS = 3. This keeps the re-grant gap short enough that every idle clock between a chained hold and the next grant can be counted one by one. An off-by-one in the gap counter or in the turnaround clock therefore changes the exact clock in which the second grant appears.

// File: rtl/phy_link_seq.sv
module phy_link_seq #(
  parameter int GAP_CLKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arb_won_i,
  input  logic       req_speed_i,
  input  logic       imm_pend_i,
  input  logic       rx_dataon_i,
  input  logic       rx_pkt_start_i,
  input  logic       rx_speed_i,
  input  logic       rx_sym_vld_i,
  input  logic [0:3] rx_sym_i,
  input  logic [1:0] link_ctl_i,
  input  logic [0:3] link_d_i,
  output logic [1:0] ctl_o,
  output logic       ctl_oe_o,
  output logic [0:3] d_o,
  output logic       d_oe_o,
  output logic       won_o,
  output logic       lost_o,
  output logic       tx_vld_o,
  output logic [0:3] tx_sym_o
);

  localparam int CW = (GAP_CLKS < 2) ? 1 : $clog2(GAP_CLKS + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CLKS - 1);

  localparam logic [1:0] P_IDLE = 2'b00;
  localparam logic [1:0] P_RECV = 2'b10;
  localparam logic [1:0] P_GRANT = 2'b11;
  localparam logic [1:0] L_REL = 2'b00;
  localparam logic [1:0] L_HOLD = 2'b01;
  localparam logic [1:0] L_XMIT = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_GNT1, S_GNT2, S_LINK, S_HWAIT, S_TURN, S_GAP, S_RXW, S_RXD
  } st_t;

  st_t st, st_n;
  logic sent_q, chain_q, tx_spd_q, rx_spd_q, lost_q, tx_vld_q;
  logic [0:3] dreg_q, tx_sym_q;
  logic [CW-1:0] gap_q;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (rx_dataon_i) st_n = S_RXW;
               else if (arb_won_i) st_n = S_GNT1;
      S_GNT1:  st_n = S_GNT2;
      S_GNT2:  st_n = S_LINK;
      S_LINK:  if (link_ctl_i == L_REL) st_n = S_TURN;
               else if (link_ctl_i == L_HOLD && sent_q) st_n = S_HWAIT;
      S_HWAIT: if (link_ctl_i == L_REL) st_n = S_TURN;
      S_TURN:  st_n = chain_q ? S_GAP : S_IDLE;
      S_GAP:   if (gap_q == GAP_LAST) st_n = S_GNT1;
      S_RXW, S_RXD:
               if (!rx_dataon_i) st_n = imm_pend_i ? S_GNT1 : S_IDLE;
               else if (st == S_RXW && rx_pkt_start_i) st_n = S_RXD;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sent_q   <= 1'b0;
      chain_q  <= 1'b0;
      tx_spd_q <= 1'b0;
      rx_spd_q <= 1'b0;
      lost_q   <= 1'b0;
      tx_vld_q <= 1'b0;
      dreg_q   <= 4'b0000;
      tx_sym_q <= 4'b0000;
      gap_q    <= '0;
    end else begin
      st     <= st_n;
      lost_q <= (st == S_IDLE) && (st_n == S_RXW);

      if (st_n == S_GNT1 && st != S_GAP) tx_spd_q <= req_speed_i;

      if (st == S_GNT2) sent_q <= 1'b0;
      else if (st == S_LINK && link_ctl_i == L_XMIT) sent_q <= 1'b1;

      if (st == S_HWAIT && link_ctl_i == L_REL) chain_q <= 1'b1;
      else if (st == S_TURN) chain_q <= 1'b0;

      gap_q <= (st == S_GAP) ? gap_q + 1'b1 : '0;

      if (st == S_RXW && rx_dataon_i && rx_pkt_start_i) begin
        rx_spd_q <= rx_speed_i;
        dreg_q   <= rx_speed_i ? 4'b0100 : 4'b0000;
      end else if (st == S_RXD && rx_dataon_i && rx_sym_vld_i) begin
        dreg_q <= rx_spd_q ? rx_sym_i : {rx_sym_i[0:1], 2'b00};
      end

      tx_vld_q <= (st == S_LINK) && (link_ctl_i == L_XMIT);
      tx_sym_q <= tx_spd_q ? link_d_i : {link_d_i[0:1], 2'b00};
    end
  end

  assign ctl_o = (st == S_GNT1) ? P_GRANT :
                 (st == S_RXW || st == S_RXD) ? P_RECV : P_IDLE;
  assign ctl_oe_o = (st == S_IDLE) || (st == S_GNT1) || (st == S_GNT2) ||
                    (st == S_GAP) || (st == S_RXW) || (st == S_RXD);
  assign d_oe_o = ctl_oe_o;
  assign d_o = (st == S_RXW) ? 4'b1111 : (st == S_RXD) ? dreg_q : 4'b0000;
  assign won_o = (st == S_GNT1);
  assign lost_o = lost_q;
  assign tx_vld_o = tx_vld_q;
  assign tx_sym_o = tx_vld_q ? tx_sym_q : 4'b0000;

endmodule

// File: rtl/phy_link_seq_chk.sv
module phy_link_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_o,
  input logic       ctl_oe_o,
  input logic [0:3] d_o,
  input logic       won_o,
  input logic       lost_o
);

  p_grant_then_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_o && ctl_o == 2'b11) |=> (ctl_oe_o && ctl_o == 2'b00));

  p_grant_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_o && ctl_o == 2'b11) |=> ##1 !ctl_oe_o);

  p_resume_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_oe_o) |-> (ctl_o == 2'b00 && d_o == 4'b0000));

  p_won_on_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    won_o |-> (ctl_oe_o && ctl_o == 2'b11));

  p_lost_prefix_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> (ctl_oe_o && ctl_o == 2'b10 && d_o == 4'b1111));

  p_recv_keeps_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe_o && ctl_o == 2'b10) |=> ctl_oe_o);

endmodule

bind phy_link_seq phy_link_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_o(ctl_o), .ctl_oe_o(ctl_oe_o),
  .d_o(d_o), .won_o(won_o), .lost_o(lost_o)
);

// File: tb/phy_link_seq_tb.sv
module phy_link_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arb_won_i = 0, req_speed_i = 0, imm_pend_i = 0, rx_dataon_i = 0;
  logic rx_pkt_start_i = 0, rx_speed_i = 0, rx_sym_vld_i = 0;
  logic [0:3] rx_sym_i = 4'b0000, link_d_i = 4'b0000, d_o, tx_sym_o;
  logic [1:0] link_ctl_i = 2'b00, ctl_o;
  logic ctl_oe_o, d_oe_o, won_o, lost_o, tx_vld_o;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_link_seq #(.GAP_CLKS(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .arb_won_i(arb_won_i), .req_speed_i(req_speed_i),
    .imm_pend_i(imm_pend_i), .rx_dataon_i(rx_dataon_i), .rx_pkt_start_i(rx_pkt_start_i),
    .rx_speed_i(rx_speed_i), .rx_sym_vld_i(rx_sym_vld_i), .rx_sym_i(rx_sym_i),
    .link_ctl_i(link_ctl_i), .link_d_i(link_d_i), .ctl_o(ctl_o), .ctl_oe_o(ctl_oe_o),
    .d_o(d_o), .d_oe_o(d_oe_o), .won_o(won_o), .lost_o(lost_o),
    .tx_vld_o(tx_vld_o), .tx_sym_o(tx_sym_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "ctl", ctl_o, 2'b00);
    chk(req, "oe", {ctl_oe_o, d_oe_o}, 2'b11);
    chk(req, "d", d_o, 4'b0000);
  endtask

  task automatic nxt; @(negedge clk); endtask

  task automatic t_reset;
    chk_idle("R1");
    chk("R1", "won/lost/tx", {won_o, lost_o, tx_vld_o}, 3'b000);
  endtask

  task automatic t_single_200;
    arb_won_i = 1; req_speed_i = 1;
    nxt; arb_won_i = 0;
    chk("R2", "grant ctl", ctl_o, 2'b11); chk("R2", "grant oe", ctl_oe_o, 1); chk("R2", "won", won_o, 1);
    nxt;
    chk("R2", "second ctl", ctl_o, 2'b00); chk("R2", "second oe", ctl_oe_o, 1); chk("R2", "won low", won_o, 0);
    nxt;
    chk("R2", "released", {ctl_oe_o, d_oe_o}, 2'b00);
    link_ctl_i = 2'b01;
    nxt;
    chk("R3", "hold keeps release", ctl_oe_o, 0); chk("R3", "hold no tx", tx_vld_o, 0);
    link_ctl_i = 2'b10; link_d_i = 4'b1011;
    nxt;
    chk("R3", "tx vld", tx_vld_o, 1); chk("R3", "tx sym 200", tx_sym_o, 4'b1011);
    link_d_i = 4'b0110;
    nxt;
    chk("R3", "tx sym 2", tx_sym_o, 4'b0110);
    link_ctl_i = 2'b00; link_d_i = 4'b0000;
    nxt;
    chk("R4", "turnaround oe", ctl_oe_o, 0); chk("R4", "no tx", tx_vld_o, 0);
    nxt;
    chk_idle("R4");
  endtask

  task automatic t_chain_100;
    arb_won_i = 1; req_speed_i = 0;
    nxt; arb_won_i = 0;
    chk("R2", "won", won_o, 1);
    nxt; nxt;
    link_ctl_i = 2'b10; link_d_i = 4'b1111;
    nxt;
    chk("R3", "100 mask", tx_sym_o, 4'b1100);
    link_ctl_i = 2'b01;
    nxt;
    chk("R5", "hold wait oe", ctl_oe_o, 0);
    link_ctl_i = 2'b00;
    nxt;
    chk("R5", "turnaround oe", ctl_oe_o, 0);
    req_speed_i = 1;
    for (int i = 0; i < GAP; i++) begin
      nxt;
      chk_idle("R5");
      chk("R5", "no early grant", won_o, 0);
    end
    nxt;
    chk("R5", "regrant ctl", ctl_o, 2'b11); chk("R5", "regrant won", won_o, 1);
    nxt;
    chk("R5", "regrant idle", ctl_o, 2'b00);
    nxt;
    chk("R5", "regrant release", ctl_oe_o, 0);
    link_ctl_i = 2'b10; link_d_i = 4'b1111;
    nxt;
    chk("R6", "speed kept", tx_sym_o, 4'b1100);
    link_ctl_i = 2'b00;
    nxt; nxt;
    chk_idle("R4");
    req_speed_i = 0;
  endtask

  task automatic t_rx(input logic spd, input logic [0:3] s0, input logic [0:3] s1,
                      input logic [0:3] e0, input logic [0:3] e1);
    rx_dataon_i = 1;
    nxt;
    chk("R7", "recv ctl", ctl_o, 2'b10); chk("R7", "prefix", d_o, 4'b1111); chk("R7", "lost", lost_o, 1);
    rx_pkt_start_i = 1; rx_speed_i = spd;
    nxt;
    chk("R8", "header", d_o, spd ? 4'b0100 : 4'b0000); chk("R7", "lost once", lost_o, 0);
    rx_pkt_start_i = 0; rx_sym_vld_i = 1; rx_sym_i = s0;
    nxt;
    chk("R8", "sym0", d_o, e0);
    rx_sym_i = s1;
    nxt;
    chk("R8", "sym1", d_o, e1); chk("R8", "still recv", ctl_o, 2'b10);
    rx_sym_vld_i = 0; rx_dataon_i = 0;
    nxt;
    chk_idle("R9");
  endtask

  task automatic t_rx_nopkt;
    rx_dataon_i = 1;
    nxt; nxt;
    chk("R9", "prefix held", d_o, 4'b1111);
    rx_dataon_i = 0;
    nxt;
    chk_idle("R9");
  endtask

  task automatic t_imm;
    rx_dataon_i = 1;
    nxt;
    rx_pkt_start_i = 1; rx_speed_i = 1;
    nxt;
    rx_pkt_start_i = 0; imm_pend_i = 1; rx_sym_vld_i = 1; rx_sym_i = 4'b0011;
    nxt;
    rx_sym_vld_i = 0; rx_dataon_i = 0;
    nxt;
    chk("R10", "imm grant", ctl_o, 2'b11); chk("R10", "imm won", won_o, 1);
    imm_pend_i = 0;
    nxt;
    chk("R10", "imm idle", ctl_o, 2'b00);
    nxt;
    chk("R10", "imm release", ctl_oe_o, 0);
    link_ctl_i = 2'b00;
    nxt; nxt;
    chk_idle("R4");
  endtask

  task automatic t_collide;
    rx_dataon_i = 1; arb_won_i = 1;
    nxt;
    arb_won_i = 0;
    chk("R11", "recv wins", ctl_o, 2'b10); chk("R11", "no won", won_o, 0);
    nxt;
    rx_dataon_i = 0;
    nxt;
    chk_idle("R11");
    nxt;
    chk("R11", "no late grant", {won_o, ctl_o}, 3'b000);
  endtask

  initial begin
    repeat (3) nxt;
    rst_n = 1;
    nxt;
    t_reset;
    t_single_200;
    t_chain_100;
    t_rx(1'b1, 4'b1001, 4'b0111, 4'b1001, 4'b0111);
    t_rx(1'b0, 4'b1111, 4'b0110, 4'b1100, 4'b0100);
    t_rx_nopkt;
    t_imm;
    t_collide;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule